// File: doc/BRIEF.md
# Programmable Bit-Serial CRC Engine

This block computes a 16-bit cyclic redundancy check one bit per clock. It works either as a generator, which passes the message through and then appends the check word, or as a checker, which takes in the message and its check word and raises an error flag when the remainder is wrong. A 3-bit select picks one of eight built-in configurations. Each configuration gives the feedback taps, how the register is initialized (per 4-bit group, all ones or all zeros), whether the appended check word is inverted, where the register's lowest bit takes its input from, and whether the entry is a stored residue pattern rather than a polynomial.

A frame starts by holding `init_n` low for at least one clock. That loads the preset and captures the select. With `calc` high, message bits go in at `din` and come back out at `dout` one clock later. Dropping `calc` for 16 clocks shifts the check word out, MSB first. In checker use, the message and the received check word are both clocked in with `calc` high, and `err` is then read.

Top module: `crc_serial_engine`

## Requirements
- R1: A clock edge with `rst` high clears the CRC register, the captured select, `dout` and `err`. After reset, 16 append clocks shift out all zeros.
- R2: On each edge with `init_n` low, the register loads the preset of the entry addressed by `sel`, and `sel` is captured. Bits 4g+3..4g are all ones when bit g of the entry's group pattern is 1, and all zeros otherwise.
- R3: While `init_n` is high, `sel` has no effect. The captured entry stays in force until the next initialize.
- R4: With `init_n` high and `calc` high, each edge computes fb = din XOR register MSB. The register shifts left, with fb (or `din`, per R6) entering bit 0, and it is XORed with the taps on bits 15..1 when fb is 1. `dout` equals the previous cycle's `din`.
- R5: With `init_n` high and `calc` low, feedback is off. `dout` takes the register MSB, inverted for inverting entries, and the register shifts left with zero fill. 16 such clocks emit the remainder.
- R6: For a residue entry, fb is forced to 0 and bit 0 takes `din`, so the register is a plain 16-bit shift register.
- R7: After each edge, `err` is 1 exactly when the register just loaded differs from the entry's expected residue. The expected residue is 0 for non-inverting polynomial entries. For inverting entries it is the value reached by clocking 16 one-bits in calculate mode from an all-zero register. For residue entries it is the stored 16-bit pattern.
- R8: Entry table (taps / group pattern bits 3..0 / inverted): 0: 8005/0000/no; 1: 1021/1111/no; 2: 1021/0000/no; 3: 1021/1111/yes; 4: 8005/1111/no; 5: 3D65/0000/yes; 6: 8BB7/0101/no; 7: residue pattern A5C3, groups 0000, no inversion.
- R9: Initialize has priority over `calc` and `din`, and `dout` is 0 after an initialize edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Active-low synchronous initialize; loads preset, captures select |
| calc | input | 1 | 1 = calculate (shift data in), 0 = append check word |
| din | input | 1 | Serial data in, MSB first |
| sel | input | SEL_W | Configuration entry select |
| dout | output | 1 | Registered serial output: data echo or check word |
| err | output | 1 | Registered remainder-mismatch flag |

## Verification
The bench builds the engine with its default select width of 3. This makes all eight configuration entries reachable, so the four distinct tap sets, the mixed group preset, both inversion settings and the residue entry are each exercised. An inverting entry with a nonzero preset and an inverting entry with a zero preset both pass through the generate-then-check loop. This shows that the fixed residue constant does not depend on the preset. The residue entry shows the plain shift path, with no feedback, through the append output.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  localparam int CRC_W = 16;
  localparam int GRP_W = 4;
  localparam int N_GRP = CRC_W / GRP_W;

  typedef struct packed {
    logic [CRC_W-1:0] taps;        // polynomial taps, or stored pattern for residue entries
    logic [N_GRP-1:0] grp_set;     // per-group preset: 1 = ones, 0 = zeros
    logic             inv_out;     // invert appended check word
    logic             lsb_from_fb; // bit 0 takes feedback (1) or raw data (0)
    logic             is_residue;  // entry is a residue pattern, feedback inhibited
  } crc_cfg_t;

  function automatic crc_cfg_t cfg_entry(input int idx);
    crc_cfg_t e;
    case (idx)
      0:       e = '{16'h8005, 4'b0000, 1'b0, 1'b1, 1'b0};
      1:       e = '{16'h1021, 4'b1111, 1'b0, 1'b1, 1'b0};
      2:       e = '{16'h1021, 4'b0000, 1'b0, 1'b1, 1'b0};
      3:       e = '{16'h1021, 4'b1111, 1'b1, 1'b1, 1'b0};
      4:       e = '{16'h8005, 4'b1111, 1'b0, 1'b1, 1'b0};
      5:       e = '{16'h3D65, 4'b0000, 1'b1, 1'b1, 1'b0};
      6:       e = '{16'h8BB7, 4'b0101, 1'b0, 1'b1, 1'b0};
      7:       e = '{16'hA5C3, 4'b0000, 1'b0, 1'b0, 1'b1};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [CRC_W-1:0] expand_groups(input logic [N_GRP-1:0] g);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < N_GRP; i++) r[i*GRP_W +: GRP_W] = {GRP_W{g[i]}};
    return r;
  endfunction

  // Remainder left after an inverted check word: 16 one-bits run from zero.
  function automatic logic [CRC_W-1:0] ones_residue(input logic [CRC_W-1:0] taps);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = 0; i < CRC_W; i++) begin
      fb = 1'b1 ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & taps);
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_cfg_rom.sv
module crc_cfg_rom
  import crc_serial_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] addr,
  output crc_cfg_t         cfg,
  output logic [CRC_W-1:0] expect_res
);
  localparam int DEPTH = 1 << SEL_W;

  crc_cfg_t         table_q [DEPTH];
  logic [CRC_W-1:0] resid_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_q[i] = cfg_entry(i);
    assign resid_q[i] = table_q[i].is_residue ? table_q[i].taps :
                        table_q[i].inv_out    ? ones_residue(table_q[i].taps) :
                                                '0;
  end

  assign cfg        = table_q[addr];
  assign expect_res = resid_q[addr];
endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core
  import crc_serial_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init_n,
  input  logic             calc,
  input  logic             din,
  input  crc_cfg_t         cfg,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nxt
);
  logic fb;
  logic lsb_in;

  always_comb begin
    fb     = cfg.is_residue ? 1'b0 : (din ^ crc_q[CRC_W-1]);
    lsb_in = cfg.lsb_from_fb ? fb : din;
    if (!init_n)
      crc_nxt = expand_groups(cfg.grp_set);
    else if (calc)
      crc_nxt = {crc_q[CRC_W-2:0], lsb_in} ^ ({CRC_W{fb}} & {cfg.taps[CRC_W-1:1], 1'b0});
    else
      crc_nxt = {crc_q[CRC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else     crc_q <= crc_nxt;
  end
endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage
  import crc_serial_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init_n,
  input  logic             calc,
  input  logic             din,
  input  logic             msb,
  input  logic             inv_out,
  input  logic [CRC_W-1:0] crc_nxt,
  input  logic [CRC_W-1:0] expect_res,
  output logic             dout,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      err  <= 1'b0;
    end else begin
      dout <= !init_n ? 1'b0 : (calc ? din : (msb ^ inv_out));
      err  <= (crc_nxt != expect_res);
    end
  end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_n,
  input  logic             calc,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout,
  output logic             err
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] rom_addr;
  crc_cfg_t         cur_cfg;
  logic [CRC_W-1:0] expect_res;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic             cfg_inv;
  logic             cfg_res;

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= '0;
    else if (!init_n) sel_q <= sel;
  end

  assign rom_addr = init_n ? sel_q : sel;
  assign cfg_inv  = cur_cfg.inv_out;
  assign cfg_res  = cur_cfg.is_residue;

  crc_cfg_rom #(.SEL_W(SEL_W)) rom_i (
    .addr       (rom_addr),
    .cfg        (cur_cfg),
    .expect_res (expect_res)
  );

  crc_shift_core core_i (
    .clk     (clk),
    .rst     (rst),
    .init_n  (init_n),
    .calc    (calc),
    .din     (din),
    .cfg     (cur_cfg),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  crc_out_stage out_i (
    .clk        (clk),
    .rst        (rst),
    .init_n     (init_n),
    .calc       (calc),
    .din        (din),
    .msb        (crc_q[CRC_W-1]),
    .inv_out    (cur_cfg.inv_out),
    .crc_nxt    (crc_nxt),
    .expect_res (expect_res),
    .dout       (dout),
    .err        (err)
  );
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk
  import crc_serial_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             init_n,
  input logic             calc,
  input logic             din,
  input logic [SEL_W-1:0] sel,
  input logic             dout,
  input logic             err,
  input logic [CRC_W-1:0] crc_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             cfg_inv,
  input logic             cfg_res
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (crc_q == '0 && !dout && !err && sel_q == '0));

  p_sel_take_r2: assert property (@(posedge clk) disable iff (rst)
    !init_n |=> sel_q == $past(sel));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    init_n |=> sel_q == $past(sel_q));

  p_calc_echo_r4: assert property (@(posedge clk) disable iff (rst)
    (init_n && calc) |=> dout == $past(din));

  p_append_out_r5: assert property (@(posedge clk) disable iff (rst)
    (init_n && !calc) |=> (dout == ($past(crc_q[CRC_W-1]) ^ $past(cfg_inv))
                           && crc_q == {$past(crc_q[CRC_W-2:0]), 1'b0}));

  p_residue_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (init_n && calc && cfg_res) |=> crc_q == {$past(crc_q[CRC_W-2:0]), $past(din)});

  p_init_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !init_n |=> !dout);
endmodule

bind crc_serial_engine crc_serial_engine_chk #(.SEL_W(SEL_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .init_n  (init_n),
  .calc    (calc),
  .din     (din),
  .sel     (sel),
  .dout    (dout),
  .err     (err),
  .crc_q   (crc_q),
  .sel_q   (sel_q),
  .cfg_inv (cfg_inv),
  .cfg_res (cfg_res)
);

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_n = 1'b1;
  logic       calc = 1'b0;
  logic       din = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       dout;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc_serial_engine #(.SEL_W(3)) dut_i (
    .clk(clk), .rst(rst), .init_n(init_n), .calc(calc),
    .din(din), .sel(sel), .dout(dout), .err(err)
  );

  // Entry table as stated in R8
  function automatic logic [15:0] e_poly(input int e);
    case (e)
      0, 4: return 16'h8005;
      1, 2, 3: return 16'h1021;
      5: return 16'h3D65;
      6: return 16'h8BB7;
      default: return 16'hA5C3;
    endcase
  endfunction
  function automatic logic [15:0] e_preset(input int e);
    case (e)
      1, 3, 4: return 16'hFFFF;
      6: return 16'h0F0F;
      default: return 16'h0000;
    endcase
  endfunction
  function automatic logic e_inv(input int e);
    return (e == 3 || e == 5);
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] poly, input logic [15:0] start,
                                          input logic [63:0] msg, input int n);
    logic [15:0] c = start;
    for (int i = n - 1; i >= 0; i--) begin
      if (msg[i] ^ c[15]) c = {c[14:0], 1'b0} ^ poly;
      else                c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_init(input int e);
    init_n = 1'b0; sel = 3'(e); calc = 1'b1; din = 1'b1;
    tick();
    init_n = 1'b1; sel = ~3'(e); // select changes after init: must be ignored
  endtask

  task automatic feed(input logic [63:0] bits, input int n, input int echo_chk);
    for (int i = n - 1; i >= 0; i--) begin
      calc = 1'b1; din = bits[i];
      tick();
      if (echo_chk != 0) check("R4 echo", {15'd0, dout}, {15'd0, bits[i]});
    end
  endtask

  task automatic read_word(output logic [15:0] w);
    calc = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      tick();
      w[i] = dout;
    end
  endtask

  task automatic t_reset();
    logic [15:0] w;
    rst = 1'b1; tick(); tick();
    check("R1 dout", {15'd0, dout}, 16'd0);
    check("R1 err", {15'd0, err}, 16'd0);
    rst = 1'b0;
    read_word(w);
    check("R1 register zero", w, 16'h0000);
  endtask

  task automatic t_presets();
    logic [15:0] w;
    for (int e = 0; e < 8; e++) begin
      do_init(e);
      check("R9 dout quiet on init", {15'd0, dout}, 16'd0);
      read_word(w);
      check("R2 preset", w, e_preset(e) ^ (e_inv(e) ? 16'hFFFF : 16'h0));
    end
  endtask

  task automatic t_gen_check(input int e, input logic [31:0] msg);
    logic [15:0] w, crc, tail;
    do_init(e);
    check("R7 err after init", {15'd0, err}, {15'd0, e_preset(e) != (e_inv(e) ?
          ref_crc(e_poly(e), 16'h0, 64'hFFFF, 16) : 16'h0)});
    feed({32'd0, msg}, 32, 1);
    read_word(w);
    crc = ref_crc(e_poly(e), e_preset(e), {32'd0, msg}, 32);
    check(e_inv(e) ? "R5 inverted check word" : "R4 check word", w,
          crc ^ (e_inv(e) ? 16'hFFFF : 16'h0));
    read_word(tail);
    check("R5 zero fill", tail, e_inv(e) ? 16'hFFFF : 16'h0000);
    // checker: good frame
    do_init(e);
    sel = 3'(e + 3); // R3: moving sel mid-frame must not matter
    feed({16'd0, msg, w}, 48, 0);
    check("R7 good frame err", {15'd0, err}, 16'd0);
    check("R3 select ignored", {15'd0, err}, 16'd0);
    // checker: corrupted frame
    do_init(e);
    feed({16'd0, msg ^ 32'h0000_0100, w}, 48, 0);
    check("R7 bad frame err", {15'd0, err}, 16'd1);
  endtask

  task automatic t_residue();
    logic [15:0] w;
    do_init(7);
    feed(64'hA5C3, 16, 0);
    check("R7 residue match", {15'd0, err}, 16'd0);
    feed(64'h0, 1, 0);
    check("R7 residue mismatch", {15'd0, err}, 16'd1);
    read_word(w);
    check("R6 plain shift contents", w, 16'h4B86);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_presets();
    t_gen_check(1, 32'h3132_3334);
    t_gen_check(3, 32'hDEAD_BEEF);
    t_gen_check(5, 32'h0000_0001);
    t_gen_check(6, 32'h8000_F00D);
    t_gen_check(0, 32'h1234_5678);
    t_residue();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule